// File: doc/BRIEF.md
# Supply Fault and Double-Hiccup Supervisor

This block is the digital sequencer inside an offline switching controller. It watches a handful of comparator flags on the controller supply rail and the peak-current limiter. From them it decides when the power switch may be driven, when the soft-start ramp is in force, and when the part must latch off and ask for the supply clamp. Every threshold is taken as a ready-made digital flag. All time constants are counted in system-clock ticks.

After power-up the supervisor waits for the supply to pass its start threshold, then enables drive with a soft-start window. A sustained current-limit condition is an overload. A strap input selects how the part responds to it. In auto-recovery mode the part hiccups: drive stops, the next supply recharge is deliberately skipped, and switching resumes on the recharge after that. In latch mode the part latches off. A supply overvoltage that persists over consecutive switching cycles always latches the part. Only a supply collapse clears the latch.

Top module: `supply_fault_supervisor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, drive_en_o, soft_start_o and fault_latched_o are all 0, and the block waits for a start request.
- R2: While the block is waiting, vcc_above_start_i = 1 at a clock edge sets drive_en_o = 1 from that edge. soft_start_o is then 1 for exactly SS_TICKS cycles, counted from that same edge.
- R3: While driving, vcc_below_stop_i = 1 at a clock edge clears drive_en_o at that edge. Drive resumes only on a later vcc_above_start_i.
- R4: peak_limit_i = 1 on OVLD_TICKS consecutive cycles while driving stops drive at the OVLD_TICKS-th edge. A single low cycle before then restarts the count from zero.
- R5: With latch_mode_i = 0, an overload stop starts a double hiccup, which runs as follows. The block waits for vcc_below_stop_i. It then ignores the next vcc_above_start_i. It waits for vcc_below_stop_i again. Only the start request after that enables drive.
- R6: With latch_mode_i = 1, sampled when the overload is confirmed, an overload sets fault_latched_o = 1 instead of starting a hiccup.
- R7: If vcc_over_i = 1 on OVP_CYCLES consecutive sw_tick_i pulses, fault_latched_o = 1 and drive_en_o = 0 from the edge of the last such pulse, in any unlatched state. A tick seen with vcc_over_i = 0 clears the count. Cycles without a tick leave the count unchanged.
- R8: While latched, start requests are ignored and fault_latched_o stays 1 until vcc_below_stop_i = 1. The block then returns to waiting, and the next start request begins a fresh start-up.
- R9: Every start-up, including the restart after a double hiccup and the one after a latch is cleared, opens a full soft-start window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_above_start_i | input | 1 | Supply is above the start threshold |
| vcc_below_stop_i | input | 1 | Supply is below the stop threshold |
| vcc_over_i | input | 1 | Supply overvoltage comparator |
| peak_limit_i | input | 1 | Peak-current limit is active this cycle |
| sw_tick_i | input | 1 | One-cycle pulse per switching period |
| latch_mode_i | input | 1 | 1 = latch on overload, 0 = auto-recovery |
| drive_en_o | output | 1 | Power switch drive may be issued |
| soft_start_o | output | 1 | Soft-start window is active |
| fault_latched_o | output | 1 | Part is latched off; enables the supply clamp |

## Verification
The assertions assume that the two supply flags are never both 1 in the same cycle, since a rail cannot be above the start level and below the stop level at once. They also assume that SS_TICKS, OVLD_TICKS and OVP_CYCLES are at least 1. The random stimulus keeps to these limits. It draws the supply as a single three-level variable (low, middle, high) that maps to mutually exclusive flags. Each level is held for random stretches, so that full hiccup and latch sequences occur. Current-limit and overvoltage flags toggle with low probability, so that bursts both shorter and longer than the timers occur.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [2:0] {
        ST_WAIT      = 3'd0,
        ST_RUN       = 3'd1,
        ST_HIC_FALL1 = 3'd2,
        ST_HIC_SKIP  = 3'd3,
        ST_HIC_FALL2 = 3'd4,
        ST_LATCH     = 3'd5
    } sup_state_e;

endpackage

// File: rtl/sup_ovld_timer.sv
module sup_ovld_timer #(
    parameter int unsigned LIMIT = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic hit_i,
    output logic expire_o
);
    localparam int unsigned W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = en_i && hit_i && (cnt_q == W'(LIMIT - 1));
        if (!en_i || !hit_i || expire_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sup_ovp_filter.sv
module sup_ovp_filter #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic over_i,
    output logic fire_o
);
    localparam int unsigned W = $clog2(CYCLES + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        fire_o = en_i && tick_i && over_i && (cnt_q == W'(CYCLES - 1));
        cnt_d  = cnt_q;
        if (!en_i || fire_o) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = over_i ? cnt_q + 1'b1 : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/supply_fault_supervisor.sv
module supply_fault_supervisor #(
    parameter int unsigned SS_TICKS   = 40000,
    parameter int unsigned OVLD_TICKS = 500000,
    parameter int unsigned OVP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_above_start_i,
    input  logic vcc_below_stop_i,
    input  logic vcc_over_i,
    input  logic peak_limit_i,
    input  logic sw_tick_i,
    input  logic latch_mode_i,
    output logic drive_en_o,
    output logic soft_start_o,
    output logic fault_latched_o
);
    import sup_pkg::*;

    localparam int unsigned SSW = $clog2(SS_TICKS + 1);

    typedef struct packed {
        sup_state_e     st;
        logic [SSW-1:0] ss;
    } sup_regs_t;

    sup_regs_t r_d, r_q;
    logic      ovld_expire;
    logic      ovp_fire;

    sup_ovld_timer #(.LIMIT(OVLD_TICKS)) u_ovld (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (r_q.st == ST_RUN),
        .hit_i    (peak_limit_i),
        .expire_o (ovld_expire)
    );

    sup_ovp_filter #(.CYCLES(OVP_CYCLES)) u_ovp (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (r_q.st != ST_LATCH),
        .tick_i (sw_tick_i),
        .over_i (vcc_over_i),
        .fire_o (ovp_fire)
    );

    always_comb begin
        r_d = r_q;
        if (r_q.st == ST_RUN && r_q.ss != '0) begin
            r_d.ss = r_q.ss - 1'b1;
        end
        unique case (r_q.st)
            ST_WAIT: begin
                if (ovp_fire) begin
                    r_d.st = ST_LATCH;
                end else if (vcc_above_start_i) begin
                    r_d.st = ST_RUN;
                    r_d.ss = SSW'(SS_TICKS);
                end
            end
            ST_RUN: begin
                if (ovp_fire) begin
                    r_d.st = ST_LATCH;
                end else if (vcc_below_stop_i) begin
                    r_d.st = ST_WAIT;
                end else if (ovld_expire) begin
                    r_d.st = latch_mode_i ? ST_LATCH : ST_HIC_FALL1;
                end
            end
            ST_HIC_FALL1: begin
                if (ovp_fire)              r_d.st = ST_LATCH;
                else if (vcc_below_stop_i) r_d.st = ST_HIC_SKIP;
            end
            ST_HIC_SKIP: begin
                if (ovp_fire)               r_d.st = ST_LATCH;
                else if (vcc_above_start_i) r_d.st = ST_HIC_FALL2;
            end
            ST_HIC_FALL2: begin
                if (ovp_fire)              r_d.st = ST_LATCH;
                else if (vcc_below_stop_i) r_d.st = ST_WAIT;
            end
            ST_LATCH: begin
                if (vcc_below_stop_i) r_d.st = ST_WAIT;
            end
            default: r_d.st = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= ST_WAIT;
            r_q.ss <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign drive_en_o      = (r_q.st == ST_RUN);
    assign soft_start_o    = (r_q.st == ST_RUN) && (r_q.ss != '0);
    assign fault_latched_o = (r_q.st == ST_LATCH);
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
    parameter int unsigned OVLD_TICKS = 500000
) (
    input logic clk,
    input logic rst_n,
    input logic vcc_below_stop_i,
    input logic peak_limit_i,
    input logic drive_en_o,
    input logic soft_start_o,
    input logic fault_latched_o
);
    localparam int unsigned CW = $clog2(OVLD_TICKS + 2);

    logic [CW-1:0] hit_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_run_q <= '0;
        end else if (drive_en_o && peak_limit_i) begin
            if (hit_run_q != CW'(OVLD_TICKS + 1)) hit_run_q <= hit_run_q + 1'b1;
        end else begin
            hit_run_q <= '0;
        end
    end

    // Soft-start opens at every start of drive (R2, R9)
    p_ss_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en_o) |-> soft_start_o);

    p_ss_inside_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_start_o |-> drive_en_o);

    p_stop_on_low_supply_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en_o && vcc_below_stop_i) |=> !drive_en_o);

    p_ovld_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en_o |-> (hit_run_q < CW'(OVLD_TICKS)));

    p_latch_blocks_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched_o |-> !drive_en_o);

    p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched_o && !vcc_below_stop_i) |=> fault_latched_o);

    p_latch_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_latched_o) |-> (!drive_en_o && $past(vcc_below_stop_i)));
endmodule

bind supply_fault_supervisor sfs_checker #(.OVLD_TICKS(OVLD_TICKS)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .vcc_below_stop_i (vcc_below_stop_i),
    .peak_limit_i     (peak_limit_i),
    .drive_en_o       (drive_en_o),
    .soft_start_o     (soft_start_o),
    .fault_latched_o  (fault_latched_o)
);

// File: tb/supply_fault_supervisor_bench.sv
`timescale 1ns/1ps
module supply_fault_supervisor_bench;
    localparam int SS   = 8;
    localparam int OVLD = 20;
    localparam int OVPN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic on_r = 0, off_r = 0, ovp_r = 0, ilim_r = 0, tick_r = 0, mode_r = 0;
    logic drive, ss, latched;

    int n_tests = 0;
    int n_fail  = 0;
    bit done = 0;

    // model: 0 wait, 1 run, 2 fall1, 3 skip, 4 fall2, 5 latch
    int m_st = 0, m_ss = 0, m_ov = 0, m_ovp = 0;

    always #5 clk = ~clk;

    supply_fault_supervisor #(.SS_TICKS(SS), .OVLD_TICKS(OVLD), .OVP_CYCLES(OVPN))
    u_supply_fault_supervisor (
        .clk(clk), .rst_n(rst_n),
        .vcc_above_start_i(on_r), .vcc_below_stop_i(off_r), .vcc_over_i(ovp_r),
        .peak_limit_i(ilim_r), .sw_tick_i(tick_r), .latch_mode_i(mode_r),
        .drive_en_o(drive), .soft_start_o(ss), .fault_latched_o(latched)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic logic exp_drive(); return m_st == 1; endfunction
    function automatic logic exp_ss();    return (m_st == 1) && (m_ss != 0); endfunction
    function automatic logic exp_latch(); return m_st == 5; endfunction

    task automatic model_next();
        bit fire, expd;
        int nst;
        fire = (m_st != 5) && tick_r && ovp_r && (m_ovp == OVPN - 1);
        expd = (m_st == 1) && ilim_r && (m_ov == OVLD - 1);
        nst = m_st;
        case (m_st)
            0: if (fire) nst = 5; else if (on_r) nst = 1;
            1: if (fire) nst = 5; else if (off_r) nst = 0;
               else if (expd) nst = mode_r ? 5 : 2;
            2: if (fire) nst = 5; else if (off_r) nst = 3;
            3: if (fire) nst = 5; else if (on_r) nst = 4;
            4: if (fire) nst = 5; else if (off_r) nst = 0;
            default: if (off_r) nst = 0;
        endcase
        if (m_st == 5 || fire) m_ovp = 0;
        else if (tick_r) m_ovp = ovp_r ? m_ovp + 1 : 0;
        if (m_st != 1 || !ilim_r || expd) m_ov = 0; else m_ov = m_ov + 1;
        if (m_st == 0 && nst == 1) m_ss = SS;
        else if (m_st == 1 && m_ss != 0) m_ss = m_ss - 1;
        m_st = nst;
    endtask

    task automatic cmp(string tag);
        chk({tag, " drive"}, drive, exp_drive());
        chk({tag, " softstart"}, ss, exp_ss());
        chk({tag, " latched"}, latched, exp_latch());
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) begin
            model_next();
            @(negedge clk);
            cmp(tag);
        end
    endtask

    task automatic ticks(int k, string tag);
        for (int i = 0; i < k; i++) begin
            tick_r = 1; run(1, tag);
            tick_r = 0; run(2, tag);
        end
    endtask

    task automatic supply(int lvl);
        off_r = (lvl == 0);
        on_r  = (lvl == 2);
    endtask

    initial begin
        int lvl;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk("R1 reset drive", drive, 1'b0);
        chk("R1 reset latched", latched, 1'b0);
        rst_n = 1;
        run(2, "R1 idle");
        chk("R1 idle drive", drive, 1'b0);

        // R2 start-up and soft-start length
        supply(2); run(1, "R2");
        chk("R2 drive on", drive, 1'b1);
        chk("R2 softstart on", ss, 1'b1);
        supply(1); run(SS - 1, "R2");
        chk("R2 softstart last", ss, 1'b1);
        run(1, "R2");
        chk("R2 softstart end", ss, 1'b0);

        // R4 short burst resets, long burst stops
        ilim_r = 1; run(OVLD - 1, "R4");
        ilim_r = 0; run(1, "R4");
        chk("R4 burst reset drive", drive, 1'b1);
        ilim_r = 1; run(OVLD - 1, "R4");
        chk("R4 below limit drive", drive, 1'b1);
        run(1, "R4");
        chk("R4 overload stop", drive, 1'b0);
        chk("R4 not latched", latched, 1'b0);

        // R5 double hiccup, R9 soft-start on restart
        ilim_r = 0; supply(0); run(2, "R5");
        supply(2); run(3, "R5");
        chk("R5 first restart ignored", drive, 1'b0);
        supply(0); run(2, "R5");
        supply(2); run(1, "R5");
        chk("R5 second restart drive", drive, 1'b1);
        chk("R9 hiccup softstart", ss, 1'b1);
        supply(1); run(SS + 2, "R9");

        // R3 low supply stops drive
        supply(0); run(1, "R3");
        chk("R3 stop", drive, 1'b0);
        supply(1); run(3, "R3");
        chk("R3 stays off", drive, 1'b0);
        supply(2); run(1, "R3");
        chk("R3 restart", drive, 1'b1);
        supply(1); run(SS + 1, "R3");

        // R6 latch mode overload
        mode_r = 1; ilim_r = 1; run(OVLD, "R6");
        chk("R6 latched", latched, 1'b1);
        chk("R6 drive off", drive, 1'b0);
        ilim_r = 0; supply(2); run(4, "R8");
        chk("R8 start ignored", latched, 1'b1);
        chk("R8 no drive", drive, 1'b0);
        supply(0); run(1, "R8");
        chk("R8 released", latched, 1'b0);
        supply(2); run(1, "R8");
        chk("R8 fresh start", drive, 1'b1);
        chk("R9 softstart after latch", ss, 1'b1);
        supply(1); mode_r = 0;

        // R7 overvoltage over consecutive ticks
        ovp_r = 1; ticks(OVPN - 1, "R7");
        chk("R7 not yet", latched, 1'b0);
        ovp_r = 0; ticks(1, "R7");
        ovp_r = 1; ticks(OVPN - 1, "R7");
        chk("R7 count cleared", latched, 1'b0);
        run(5, "R7");
        chk("R7 no tick no count", latched, 1'b0);
        ticks(1, "R7");
        chk("R7 latched", latched, 1'b1);
        chk("R7 drive off", drive, 1'b0);
        ovp_r = 0; supply(0); run(2, "R8");
        supply(1); run(2, "R8");

        // random phase against the model (R2 R3 R4 R5 R6 R7 R8)
        lvl = 1;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 24 == 0) lvl = $urandom % 3;
            supply(lvl);
            if ($urandom % 12 == 0) ilim_r = ~ilim_r;
            if ($urandom % 80 == 0) ovp_r = ~ovp_r;
            if ($urandom % 700 == 0) mode_r = ~mode_r;
            tick_r = ($urandom % 3 == 0);
            run(1, "rand R4 R5 R7");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule